// File: doc/BRIEF.md
# Cell Modulation Command Generator

This block turns the measured state of one converter leg into a normalized duty for each of its series cells. The leg has two arms, an upper and a lower one, each with `CELLS/2` cells carrying a floating capacitor. On every sample strobe the block takes a snapshot of all its inputs. It then works through the cells one at a time. For each cell it forms a command from four parts: a shared averaging correction; a per-cell balancing term, proportional to that cell's voltage error, whose sign follows the current in its arm; an arm-dependent share of the AC reference; and a fixed share of the DC supply voltage. It divides that command by the cell's own capacitor voltage to get a duty in fixed point between 0 and 1.

The duties feed a carrier-based PWM stage, which is not part of this block. `done_o` tells the controller that all duties belong to the latest accepted strobe. A single iterative divider is shared by all cells. The whole pass therefore takes a bounded number of cycles, and that bound must fit inside one sample period.

Top module: `cell_cmd_gen`

## Requirements
- R1: Cells 0 to CELLS/2-1 (the lowest slices of `vcell_i` and `duty_o`) form the upper arm. They use `ipos_i` for current polarity and subtract the AC share. The remaining cells form the lower arm. They use `ineg_i` and add the AC share.
- R2: The balancing term is floor(gain*(vset - vcell)/2^GF), with `gain_i` unsigned and GF=6 fraction bits. It is negated when the arm current is negative. A zero arm current takes the non-negated branch.
- R3: Cell command = vavg + balancing term ∓ floor(vac/(CELLS/2)) + floor(vdc/CELLS). Both divisions are arithmetic right shifts, which round toward minus infinity. All voltages share one LSB.
- R4: Duty = floor(command*2^DW/vcell), written as DW=12 bits, where 2^DW means 1.
- R5: A command of zero or below gives a duty of 0. A quotient of 2^DW or more gives the saturated value 2^DW-1.
- R6: A cell whose snapshot voltage is below VMIN=16 gets a duty of 0, whatever its command.
- R7: `done_o` is low on the cycle after an accepted strobe. It rises once all cells have been written, within CELLS*(DW+2)+2 cycles of the strobe. Duties then hold until the next strobe.
- R8: A strobe that arrives while a pass is running is ignored. The results of that pass come from the first snapshot.
- R9: After reset every duty is 0 and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Sample strobe, one cycle |
| vcell_i | input | CELLS*VW | Cell capacitor voltages, unsigned, cell k at bits k*VW |
| vset_i | input | VW | Cell voltage setpoint, unsigned |
| gain_i | input | GW | Balancing gain, unsigned, GF fraction bits |
| ipos_i | input | IW | Upper-arm current, signed |
| ineg_i | input | IW | Lower-arm current, signed |
| vac_i | input | VW | AC voltage reference, signed |
| vdc_i | input | VW | DC supply voltage, unsigned |
| vavg_i | input | VW | Averaging correction, signed |
| duty_o | output | CELLS*DW | Normalized duties, cell k at bits k*DW |
| done_o | output | 1 | All duties belong to the last accepted strobe |

## Verification
The embedded assertions check the following on every cycle:
- the done flag stays low while a pass runs and drops right after a strobe is accepted;
- a strobe during a pass leaves the snapshot untouched;
- the divider returns zero for an under-threshold cell or a non-positive command, and full scale whenever the command reaches the cell voltage.

The exact arithmetic can only be shown by the bench's sweeps, which compare every duty with an independently computed quotient. This covers the arm-dependent sign of the AC share, the polarity flip of the balancing term (including zero current) and the floor rounding of each shift.

// File: rtl/cmdgen_pkg.sv
package cmdgen_pkg;

    // Sequencer states for the per-cell pass
    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_WAIT
    } seq_state_e;

    // Divider outcome classes chosen when a division starts
    typedef enum logic [1:0] {
        DIV_ZERO,
        DIV_FULL,
        DIV_ITER
    } div_case_e;

    // Current polarity captured at the strobe
    typedef struct packed {
        logic upper_neg;
        logic lower_neg;
    } arm_sign_t;

    // Default configuration
    localparam int DEF_CELLS = 8;
    localparam int DEF_VW    = 12;
    localparam int DEF_IW    = 16;
    localparam int DEF_GW    = 8;
    localparam int DEF_GF    = 6;
    localparam int DEF_DW    = 12;
    localparam int DEF_VMIN  = 16;

endpackage

// File: rtl/cell_cmd_former.sv
module cell_cmd_former
    import cmdgen_pkg::*;
#(
    parameter int CELLS = DEF_CELLS,
    parameter int VW    = DEF_VW,
    parameter int GW    = DEF_GW,
    parameter int GF    = DEF_GF,
    parameter int CW    = DEF_VW + DEF_GW + 4
) (
    input  logic [VW-1:0]        vcell,
    input  logic [VW-1:0]        vset,
    input  logic [GW-1:0]        gain,
    input  logic                 cur_neg,
    input  logic                 lower_arm,
    input  logic signed [VW-1:0] vac,
    input  logic [VW-1:0]        vdc,
    input  logic signed [VW-1:0] vavg,
    output logic signed [CW-1:0] cmd
);
    localparam int PW  = VW + GW + 2;
    localparam int QSH = $clog2(CELLS) - 1;
    localparam int DSH = $clog2(CELLS);

    logic signed [VW:0]    err;
    logic signed [PW-1:0]  err_x, gain_x, prod, bal;
    logic signed [CW-1:0]  bal_x, bal_s, avg_x, ac_x, dc_x;
    logic signed [VW-1:0]  ac_share;
    logic [VW-1:0]         dc_share;

    always_comb begin
        err      = $signed({1'b0, vset}) - $signed({1'b0, vcell});
        err_x    = {{(PW-VW-1){err[VW]}}, err};
        gain_x   = $signed({{(PW-GW){1'b0}}, gain});
        prod     = err_x * gain_x;
        bal      = prod >>> GF;
        bal_x    = {{(CW-PW){bal[PW-1]}}, bal};
        bal_s    = cur_neg ? -bal_x : bal_x;
        ac_share = vac >>> QSH;
        ac_x     = {{(CW-VW){ac_share[VW-1]}}, ac_share};
        dc_share = vdc >> DSH;
        dc_x     = $signed({{(CW-VW){1'b0}}, dc_share});
        avg_x    = {{(CW-VW){vavg[VW-1]}}, vavg};
        cmd      = avg_x + bal_s + (lower_arm ? ac_x : -ac_x) + dc_x;
    end

endmodule

// File: rtl/duty_divider.sv
module duty_divider
    import cmdgen_pkg::*;
#(
    parameter int VW   = DEF_VW,
    parameter int CW   = DEF_VW + DEF_GW + 4,
    parameter int DW   = DEF_DW,
    parameter int VMIN = DEF_VMIN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic signed [CW-1:0] num,
    input  logic [VW-1:0]        den,
    output logic                 valid_o,
    output logic [DW-1:0]        q_o
);
    localparam int CNW = $clog2(DW + 1);
    localparam logic [VW-1:0] VMIN_V = VW'(VMIN);

    div_case_e             dcase;
    logic signed [CW-1:0]  den_x;
    logic [VW-1:0]         rem_q;
    logic [VW:0]           rem2, diff;
    logic                  ge;
    logic [CNW-1:0]        cnt_q;
    logic                  busy_q;

    always_comb begin
        den_x = $signed({{(CW-VW){1'b0}}, den});
        if (den < VMIN_V || num[CW-1] || num == '0)
            dcase = DIV_ZERO;
        else if (num >= den_x)
            dcase = DIV_FULL;
        else
            dcase = DIV_ITER;
        rem2 = {rem_q, 1'b0};
        ge   = rem2 >= {1'b0, den};
        diff = rem2 - {1'b0, den};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            q_o     <= '0;
            rem_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (start) begin
                unique case (dcase)
                    DIV_ZERO: begin q_o <= '0; valid_o <= 1'b1; end
                    DIV_FULL: begin q_o <= '1; valid_o <= 1'b1; end
                    default: begin
                        rem_q  <= num[VW-1:0];
                        q_o    <= '0;
                        cnt_q  <= CNW'(DW);
                        busy_q <= 1'b1;
                    end
                endcase
            end else if (busy_q) begin
                rem_q <= ge ? diff[VW-1:0] : rem2[VW-1:0];
                q_o   <= {q_o[DW-2:0], ge};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNW'(1)) begin
                    busy_q  <= 1'b0;
                    valid_o <= 1'b1;
                end
            end
        end
    end

    // R7: a new division is never launched over a running one
    assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

    // R4: an iteration run ends with exactly one valid pulse
    assert_iter_finishes_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q == CNW'(1)) |=> (valid_o && !busy_q));

endmodule

// File: rtl/cell_cmd_gen.sv
module cell_cmd_gen
    import cmdgen_pkg::*;
#(
    parameter int CELLS = DEF_CELLS,
    parameter int VW    = DEF_VW,
    parameter int IW    = DEF_IW,
    parameter int GW    = DEF_GW,
    parameter int GF    = DEF_GF,
    parameter int DW    = DEF_DW,
    parameter int VMIN  = DEF_VMIN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sample_i,
    input  logic [CELLS*VW-1:0]   vcell_i,
    input  logic [VW-1:0]         vset_i,
    input  logic [GW-1:0]         gain_i,
    input  logic signed [IW-1:0]  ipos_i,
    input  logic signed [IW-1:0]  ineg_i,
    input  logic signed [VW-1:0]  vac_i,
    input  logic [VW-1:0]         vdc_i,
    input  logic signed [VW-1:0]  vavg_i,
    output logic [CELLS*DW-1:0]   duty_o,
    output logic                  done_o
);
    localparam int CW  = VW + GW + 4;
    localparam int IXW = $clog2(CELLS);
    localparam logic [IXW-1:0] LAST_IX  = IXW'(CELLS - 1);
    localparam logic [IXW-1:0] LOWER_IX = IXW'(CELLS / 2);
    localparam logic [VW-1:0]  VMIN_V   = VW'(VMIN);

    seq_state_e            state_q;
    logic [IXW-1:0]        idx_q;
    logic [CELLS*VW-1:0]   vcell_s;
    logic [VW-1:0]         vset_s, vdc_s;
    logic [GW-1:0]         gain_s;
    logic signed [VW-1:0]  vac_s, vavg_s;
    arm_sign_t             sign_s;

    logic [VW-1:0]         vcell_sel;
    logic                  lower_arm, cur_neg;
    logic signed [CW-1:0]  cmd;
    logic                  div_start, div_valid;
    logic [DW-1:0]         div_q;

    always_comb begin
        vcell_sel = vcell_s[idx_q*VW +: VW];
        lower_arm = idx_q >= LOWER_IX;
        cur_neg   = lower_arm ? sign_s.lower_neg : sign_s.upper_neg;
        div_start = state_q == SEQ_LOAD;
    end

    cell_cmd_former #(.CELLS(CELLS), .VW(VW), .GW(GW), .GF(GF), .CW(CW)) u_former (
        .vcell(vcell_sel), .vset(vset_s), .gain(gain_s), .cur_neg(cur_neg),
        .lower_arm(lower_arm), .vac(vac_s), .vdc(vdc_s), .vavg(vavg_s), .cmd(cmd)
    );

    duty_divider #(.VW(VW), .CW(CW), .DW(DW), .VMIN(VMIN)) u_div (
        .clk(clk), .rst(rst), .start(div_start), .num(cmd), .den(vcell_sel),
        .valid_o(div_valid), .q_o(div_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            done_o  <= 1'b0;
            vcell_s <= '0;
            vset_s  <= '0;
            vdc_s   <= '0;
            gain_s  <= '0;
            vac_s   <= '0;
            vavg_s  <= '0;
            sign_s  <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (sample_i) begin
                    vcell_s <= vcell_i;
                    vset_s  <= vset_i;
                    vdc_s   <= vdc_i;
                    gain_s  <= gain_i;
                    vac_s   <= vac_i;
                    vavg_s  <= vavg_i;
                    sign_s  <= '{upper_neg: ipos_i[IW-1], lower_neg: ineg_i[IW-1]};
                    idx_q   <= '0;
                    done_o  <= 1'b0;
                    state_q <= SEQ_LOAD;
                end
                SEQ_LOAD: state_q <= SEQ_WAIT;
                default: if (div_valid) begin
                    if (idx_q == LAST_IX) begin
                        done_o  <= 1'b1;
                        state_q <= SEQ_IDLE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= SEQ_LOAD;
                    end
                end
            endcase
        end
    end

    for (genvar k = 0; k < CELLS; k++) begin : g_duty
        always_ff @(posedge clk) begin
            if (rst)
                duty_o[k*DW +: DW] <= '0;
            else if (state_q == SEQ_WAIT && div_valid && idx_q == IXW'(k))
                duty_o[k*DW +: DW] <= div_q;
        end
    end

    assert_accept_clears_done_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE && sample_i) |=> !done_o);

    assert_pass_keeps_done_low_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q != SEQ_IDLE) |-> !done_o);

    assert_busy_strobe_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q != SEQ_IDLE && sample_i) |=> ($stable(vcell_s) && $stable(vdc_s) && $stable(vac_s)));

    assert_low_cell_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (div_valid && vcell_sel < VMIN_V) |-> div_q == '0);

    assert_nonpos_cmd_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (div_valid && (cmd[CW-1] || cmd == '0)) |-> div_q == '0);

    assert_full_scale_R5: assert property (@(posedge clk) disable iff (rst)
        (div_valid && vcell_sel >= VMIN_V && !cmd[CW-1]
         && cmd >= $signed({{(CW-VW){1'b0}}, vcell_sel})) |-> div_q == '1);

endmodule

// File: tb/cell_cmd_gen_test.sv
module cell_cmd_gen_test;
    localparam int N = 8, VW = 12, IW = 16, GW = 8, GF = 6, DW = 12, VMIN = 16;
    localparam int LIMIT = N * (DW + 2) + 2;
    localparam int FULL = (1 << DW) - 1;

    logic clk = 1'b0, rst = 1'b1, sample_i = 1'b0;
    logic [N*VW-1:0] vcell_i = '0;
    logic [VW-1:0] vset_i = '0, vdc_i = '0;
    logic [GW-1:0] gain_i = '0;
    logic signed [IW-1:0] ipos_i = '0, ineg_i = '0;
    logic signed [VW-1:0] vac_i = '0, vavg_i = '0;
    logic [N*DW-1:0] duty_o;
    logic done_o;

    int n_cmp = 0, n_bad = 0;
    int vc[N];
    int t_vset, t_gain, t_ip, t_in, t_vac, t_vdc, t_vavg;
    int unsigned seed = 32'h1234_5678;
    bit finished = 0;

    always #10 clk = ~clk;

    cell_cmd_gen uut (.clk, .rst, .sample_i, .vcell_i, .vset_i, .gain_i, .ipos_i, .ineg_i,
                      .vac_i, .vdc_i, .vavg_i, .duty_o, .done_o);

    function automatic int unsigned nxt(inout int unsigned s);
        s ^= s << 13; s ^= s >> 17; s ^= s << 5;
        return s;
    endfunction

    function automatic int cmd_of(int k);
        int bal, ac, cur;
        cur = (k < N/2) ? t_ip : t_in;
        bal = (t_gain * (t_vset - vc[k])) >>> GF;      // R2
        if (cur < 0) bal = -bal;
        ac = t_vac >>> 2;                              // R3: CELLS/2 = 4
        return t_vavg + bal + ((k < N/2) ? -ac : ac) + (t_vdc >>> 3);  // R1
    endfunction

    function automatic int exp_duty(int k);
        int c, r;
        c = cmd_of(k);
        if (vc[k] < VMIN) return 0;                    // R6
        if (c <= 0) return 0;                          // R5
        r = (c * (1 << DW)) / vc[k];                   // R4
        return (r > FULL) ? FULL : r;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic apply();
        for (int k = 0; k < N; k++) vcell_i[k*VW +: VW] = VW'(vc[k]);
        vset_i = VW'(t_vset); gain_i = GW'(t_gain); ipos_i = IW'(t_ip); ineg_i = IW'(t_in);
        vac_i = VW'(t_vac); vdc_i = VW'(t_vdc); vavg_i = VW'(t_vavg);
    endtask

    task automatic run_case(string tag, bit disturb);
        int cyc;
        apply();
        sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
        @(negedge clk);
        check("R7 done low after strobe", int'(done_o), 0);
        cyc = 1;
        if (disturb) begin
            // R8: a second strobe with other inputs mid-pass must not matter
            repeat (5) @(negedge clk);
            cyc += 5;
            vcell_i = ~vcell_i; vdc_i = 12'd100; vac_i = -12'sd900;
            sample_i = 1'b1;
            @(negedge clk);
            sample_i = 1'b0;
            cyc++;
        end
        while (!done_o && cyc <= LIMIT) begin @(negedge clk); cyc++; end
        check("R7 done within bound", int'(cyc <= LIMIT), 1);
        for (int k = 0; k < N; k++) begin
            string t;
            t = $sformatf("%s cell%0d", tag, k);
            check(t, int'(duty_o[k*DW +: DW]), exp_duty(k));
        end
        // R7: duties hold after done
        repeat (3) @(negedge clk);
        for (int k = 0; k < N; k++)
            check("R7 hold", int'(duty_o[k*DW +: DW]), exp_duty(k));
    endtask

    task automatic base();
        for (int k = 0; k < N; k++) vc[k] = 400;
        t_vset = 400; t_gain = 64; t_ip = 10; t_in = 10;
        t_vac = 0; t_vdc = 1600; t_vavg = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < N; k++)
            check("R9 reset duty", int'(duty_o[k*DW +: DW]), 0);
        check("R9 reset done", int'(done_o), 0);

        base(); run_case("R3 R4 balanced", 0);                 // 200/400 -> 2048
        base(); t_vac = 400; run_case("R1 arm split", 0);      // upper 100, lower 300
        base(); t_vac = 1700; run_case("R1 R5 clamp", 0);      // upper negative, lower full
        base(); t_vac = -7; t_vavg = -3; run_case("R3 floor", 0);
        base(); for (int k = 0; k < N; k++) vc[k] = 300 + 25*k;
        t_ip = 0; t_in = 0; run_case("R2 zero current", 0);
        t_ip = -5; t_in = -5; run_case("R2 negative current", 0);
        t_ip = 5; t_in = -5; run_case("R2 mixed", 0);
        base(); vc[2] = 15; vc[6] = 0; t_vdc = 4000; run_case("R6 low cell", 0);
        base(); vc[3] = 16; run_case("R6 threshold", 0);
        base(); t_vac = 300; run_case("R8 busy strobe", 1);

        for (int n = 0; n < 250; n++) begin
            for (int k = 0; k < N; k++) begin
                vc[k] = 250 + int'(nxt(seed) % 300);
                if (nxt(seed) % 16 == 0) vc[k] = int'(nxt(seed) % 20);
            end
            t_vset = 350 + int'(nxt(seed) % 100);
            t_gain = int'(nxt(seed) % 256);
            t_ip   = int'(nxt(seed) % 5) - 2;
            t_in   = int'(nxt(seed) % 5) - 2;
            t_vac  = int'(nxt(seed) % 3001) - 1500;
            t_vdc  = 2800 + int'(nxt(seed) % 800);
            t_vavg = int'(nxt(seed) % 401) - 200;
            run_case("R4 sweep", 0);
        end
        finished = 1;
    end

    initial begin
        int wd = 0;
        while (!finished && wd < 150000) begin @(negedge clk); wd++; end
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected finish", wd);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule